// File: doc/BRIEF.md
# Bus Cycle Timeout Monitor

This block guards three kinds of bus cycle at once: cycles on the local bus, the wait for access to the backplane bus, and the backplane cycle as a whole. Each watcher starts when its start strobe arrives. It then counts microsecond ticks from a shared tick input. If the count reaches the selected limit before the matching done strobe, the watcher raises a sticky timeout flag, and the block pulses a bus-error output for one clock.

A single byte-wide configuration register sets the limits. Software writes it through a small write port at one fixed address. The register holds one 2-bit selector per watcher and one enable bit, which is passed out to an arbitration timer. Each selector picks one of three limits or turns its watcher off. The local and global watchers share one table of limits. The access watcher has a much longer table. A watcher takes its limit from the register when its cycle starts, so a register write never changes a cycle that is already running.

Top module: `cyc_tmo_mon`

## Requirements
- R1: After reset, all three timeout flags are 0, bus_err is 0, arb_tmr_en is 0, and the configuration register is 0x00, so every selector is 00.
- R2: A write with cfg_wr high loads cfg_wdata into the register only when cfg_addr equals 0x09. A write to any other address changes neither arb_tmr_en nor any timeout limit.
- R3: Watcher 0 (local cycles) takes its selector from register bits [1:0]. The limit is 102 ticks for 00, 205 for 01 and 410 for 10.
- R4: Watcher 1 (access wait) takes its selector from register bits [3:2]. The limit is 102 ticks for 00, 1600 for 01 and 51000 for 10.
- R5: Watcher 2 (global cycle) takes its selector from register bits [5:4]. The limit is 102 ticks for 00, 205 for 01 and 410 for 10.
- R6: arb_tmr_en follows register bit 6 from the clock after the write.
- R7: A start strobe resets the watcher's count to zero. The flag is set on the same clock edge as the tick that brings the count to the limit. A done strobe that arrives on or before that edge ends the cycle, and no flag is set.
- R8: When a watcher's selector is 11, that watcher never sets its flag and never causes bus_err, however long the cycle runs.
- R9: A watcher keeps the limit it latched at its start strobe, even if the register is rewritten during the cycle.
- R10: A timeout flag stays set until a 1 is applied to its own bit of tmo_clr. Clear bits for other watchers leave it unchanged. A timeout that happens on the same edge as a clear wins, and the flag stays set.
- R11: bus_err is high for exactly one clock. That clock is the one in which a timeout flag is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Active-low synchronous reset |
| us_tick | input | 1 | One-clock strobe, once every microsecond |
| cyc_start | input | 3 | Start strobe per watcher (0 local, 1 access, 2 global) |
| cyc_done | input | 3 | Done strobe per watcher |
| cfg_wr | input | 1 | Register write enable |
| cfg_addr | input | ADDR_W | Byte address of the write |
| cfg_wdata | input | 8 | Write data |
| tmo_clr | input | 3 | Write-1 clear of the timeout flags |
| tmo_flag | output | 3 | Sticky timeout flag per watcher |
| bus_err | output | 1 | One-clock bus-error pulse on a timeout |
| arb_tmr_en | output | 1 | Arbitration timer enable, from register bit 6 |

## Verification
The bound checker looks at every cycle for four things:
- a flag only rises together with bus_err, and bus_err never fires while all flags are clear;
- a set flag survives every clock that does not clear it;
- arb_tmr_en loads only on writes to the register's address;
- clearing a flag and then finding it set again needs a fresh bus-error pulse.

The exact limit for each watcher and selector cannot be seen from the ports one cycle at a time, so the bench's sweeps must show it. The same holds for the way a done strobe on the limit edge beats the timeout, for the silence of a disabled selector, and for keeping the latched limit after a write in the middle of a cycle.

// File: rtl/cyc_tmo_pkg.sv
package cyc_tmo_pkg;
   localparam int NUM_WATCH  = 3;
   localparam int SEL_W      = 2;
   localparam int CFG_W      = 8;
   localparam int ARB_BIT    = 6;
   localparam int WID_LOCAL  = 0;
   localparam int WID_ACCESS = 1;
   localparam int WID_GLOBAL = 2;
   typedef logic [SEL_W-1:0] sel_t;
   localparam sel_t SEL_OFF  = 2'b11;
endpackage

// File: rtl/cyc_tmo_cfg.sv
module cyc_tmo_cfg
   import cyc_tmo_pkg::*;
#(
   parameter int ADDR_W   = 6,
   parameter int CFG_ADDR = 9
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            wr_en,
   input  logic [ADDR_W-1:0]               wr_addr,
   input  logic [CFG_W-1:0]                wr_data,
   output logic [NUM_WATCH-1:0][SEL_W-1:0] sel_o,
   output logic                            arb_en_o
);
   localparam int HELD_W = ARB_BIT + 1;

   if (CFG_ADDR >= (1 << ADDR_W)) begin : g_bad_addr
      $error("CFG_ADDR does not fit in ADDR_W bits");
   end
   if (NUM_WATCH * SEL_W > ARB_BIT) begin : g_bad_layout
      $error("selector fields overlap the arbitration enable bit");
   end

   logic [HELD_W-1:0] cfg_q;
   logic              hit;

   assign hit = wr_en && (wr_addr == ADDR_W'(CFG_ADDR));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg_q <= '0;
      end else if (hit) begin
         cfg_q <= wr_data[HELD_W-1:0];
      end
   end

   for (genvar g = 0; g < NUM_WATCH; g++) begin : g_sel
      assign sel_o[g] = cfg_q[g*SEL_W +: SEL_W];
   end

   assign arb_en_o = cfg_q[ARB_BIT];
endmodule

// File: rtl/cyc_tmo_lut.sv
module cyc_tmo_lut
   import cyc_tmo_pkg::*;
#(
   parameter int unsigned L0    = 102,
   parameter int unsigned L1    = 205,
   parameter int unsigned L2    = 410,
   parameter int          CNT_W = 16
) (
   input  sel_t             sel,
   output logic [CNT_W-1:0] lim,
   output logic             off
);
   if (L0 == 0 || L1 == 0 || L2 == 0) begin : g_zero
      $error("timeout limits must be non-zero");
   end
   if (L0 >= (1 << CNT_W) || L1 >= (1 << CNT_W) || L2 >= (1 << CNT_W)) begin : g_wide
      $error("a timeout limit does not fit in CNT_W bits");
   end

   always_comb begin
      off = 1'b0;
      unique case (sel)
         2'b00:   lim = CNT_W'(L0);
         2'b01:   lim = CNT_W'(L1);
         2'b10:   lim = CNT_W'(L2);
         default: begin
            lim = '0;
            off = 1'b1;
         end
      endcase
   end
endmodule

// File: rtl/cyc_tmo_watch.sv
module cyc_tmo_watch
   import cyc_tmo_pkg::*;
#(
   parameter int unsigned L0    = 102,
   parameter int unsigned L1    = 205,
   parameter int unsigned L2    = 410,
   parameter int          CNT_W = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic start,
   input  logic done,
   input  sel_t sel,
   input  logic clr,
   output logic flag,
   output logic fire
);
   logic [CNT_W-1:0] lut_lim;
   logic             lut_off;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] lim_q;
   logic [CNT_W-1:0] cnt_nx;
   logic             off_q;
   logic             act_q;
   logic             hit;

   cyc_tmo_lut #(.L0(L0), .L1(L1), .L2(L2), .CNT_W(CNT_W)) lut_i (
      .sel (sel),
      .lim (lut_lim),
      .off (lut_off)
   );

   assign cnt_nx = cnt_q + 1'b1;
   assign hit    = act_q && !start && !done && tick && !off_q && (cnt_nx == lim_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act_q <= 1'b0;
         cnt_q <= '0;
         lim_q <= '0;
         off_q <= 1'b0;
      end else if (start) begin
         act_q <= 1'b1;
         cnt_q <= '0;
         lim_q <= lut_lim;
         off_q <= lut_off;
      end else if (done || hit) begin
         act_q <= 1'b0;
      end else if (act_q && tick && !off_q) begin
         cnt_q <= cnt_nx;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flag <= 1'b0;
         fire <= 1'b0;
      end else begin
         flag <= (flag && !clr) || hit;
         fire <= hit;
      end
   end
endmodule

// File: rtl/cyc_tmo_mon.sv
module cyc_tmo_mon
   import cyc_tmo_pkg::*;
#(
   parameter int          ADDR_W   = 6,
   parameter int          CFG_ADDR = 9,
   parameter int          CNT_W    = 16,
   parameter int unsigned LOC_LIM0 = 102,
   parameter int unsigned LOC_LIM1 = 205,
   parameter int unsigned LOC_LIM2 = 410,
   parameter int unsigned ACC_LIM0 = 102,
   parameter int unsigned ACC_LIM1 = 1600,
   parameter int unsigned ACC_LIM2 = 51000,
   parameter int unsigned GLB_LIM0 = 102,
   parameter int unsigned GLB_LIM1 = 205,
   parameter int unsigned GLB_LIM2 = 410
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              us_tick,
   input  logic [2:0]        cyc_start,
   input  logic [2:0]        cyc_done,
   input  logic              cfg_wr,
   input  logic [ADDR_W-1:0] cfg_addr,
   input  logic [7:0]        cfg_wdata,
   input  logic [2:0]        tmo_clr,
   output logic [2:0]        tmo_flag,
   output logic              bus_err,
   output logic              arb_tmr_en
);
   logic [NUM_WATCH-1:0][SEL_W-1:0] sel;
   logic [NUM_WATCH-1:0]            fire;

   cyc_tmo_cfg #(.ADDR_W(ADDR_W), .CFG_ADDR(CFG_ADDR)) cfg_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (cfg_wr),
      .wr_addr  (cfg_addr),
      .wr_data  (cfg_wdata),
      .sel_o    (sel),
      .arb_en_o (arb_tmr_en)
   );

   for (genvar g = 0; g < NUM_WATCH; g++) begin : g_watch
      localparam int unsigned P0 = (g == WID_ACCESS) ? ACC_LIM0 :
                                   (g == WID_LOCAL)  ? LOC_LIM0 : GLB_LIM0;
      localparam int unsigned P1 = (g == WID_ACCESS) ? ACC_LIM1 :
                                   (g == WID_LOCAL)  ? LOC_LIM1 : GLB_LIM1;
      localparam int unsigned P2 = (g == WID_ACCESS) ? ACC_LIM2 :
                                   (g == WID_LOCAL)  ? LOC_LIM2 : GLB_LIM2;
      cyc_tmo_watch #(.L0(P0), .L1(P1), .L2(P2), .CNT_W(CNT_W)) watch_i (
         .clk   (clk),
         .rst_n (rst_n),
         .tick  (us_tick),
         .start (cyc_start[g]),
         .done  (cyc_done[g]),
         .sel   (sel[g]),
         .clr   (tmo_clr[g]),
         .flag  (tmo_flag[g]),
         .fire  (fire[g])
      );
   end

   assign bus_err = |fire;
endmodule

// File: rtl/cyc_tmo_chk.sv
module cyc_tmo_chk #(
   parameter int ADDR_W   = 6,
   parameter int CFG_ADDR = 9
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_wr,
   input logic [ADDR_W-1:0] cfg_addr,
   input logic [7:0]        cfg_wdata,
   input logic [2:0]        tmo_clr,
   input logic [2:0]        tmo_flag,
   input logic              bus_err,
   input logic              arb_tmr_en
);
   logic wr_hit;
   assign wr_hit = cfg_wr && (cfg_addr == ADDR_W'(CFG_ADDR));

   // R11
   err_has_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_err |-> (tmo_flag != 3'b000));

   // R11
   flag_rise_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((tmo_flag & ~$past(tmo_flag)) != 3'b000) |-> bus_err);

   // R10
   flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (($past(tmo_flag) & ~$past(tmo_clr) & ~tmo_flag) == 3'b000));

   // R10
   clr_refire_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((tmo_flag & $past(tmo_clr)) != 3'b000) |-> bus_err);

   // R6
   arb_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_hit |=> (arb_tmr_en == $past(cfg_wdata[6])));

   // R2
   arb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_hit |=> $stable(arb_tmr_en));
endmodule

bind cyc_tmo_mon cyc_tmo_chk #(.ADDR_W(ADDR_W), .CFG_ADDR(CFG_ADDR)) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .cfg_wr     (cfg_wr),
   .cfg_addr   (cfg_addr),
   .cfg_wdata  (cfg_wdata),
   .tmo_clr    (tmo_clr),
   .tmo_flag   (tmo_flag),
   .bus_err    (bus_err),
   .arb_tmr_en (arb_tmr_en)
);

// File: tb/cyc_tmo_mon_tb.sv
module cyc_tmo_mon_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int ADDR_W     = 6;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              us_tick = 1'b0;
   logic [2:0]        cyc_start = '0;
   logic [2:0]        cyc_done = '0;
   logic              cfg_wr = 1'b0;
   logic [ADDR_W-1:0] cfg_addr = '0;
   logic [7:0]        cfg_wdata = '0;
   logic [2:0]        tmo_clr = '0;
   logic [2:0]        tmo_flag;
   logic              bus_err;
   logic              arb_tmr_en;

   int errs = 0;
   int checks = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   cyc_tmo_mon #(.ADDR_W(ADDR_W)) dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .us_tick    (us_tick),
      .cyc_start  (cyc_start),
      .cyc_done   (cyc_done),
      .cfg_wr     (cfg_wr),
      .cfg_addr   (cfg_addr),
      .cfg_wdata  (cfg_wdata),
      .tmo_clr    (tmo_clr),
      .tmo_flag   (tmo_flag),
      .bus_err    (bus_err),
      .arb_tmr_en (arb_tmr_en)
   );

   function automatic int exp_lim(int w, int s);
      if (s == 3) return 0;
      if (w == 1) begin
         case (s)
            0: return 102;
            1: return 1600;
            default: return 51000;
         endcase
      end
      case (s)
         0: return 102;
         1: return 205;
         default: return 410;
      endcase
   endfunction

   function automatic string sel_req(int w);
      if (w == 0) return "R3";
      if (w == 1) return "R4";
      return "R5";
   endfunction

   task automatic check(bit ok, string req, int act, int exp);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic wr_cfg(int addr, int data);
      cfg_wr    = 1'b1;
      cfg_addr  = ADDR_W'(addr);
      cfg_wdata = 8'(data);
      step();
      cfg_wr    = 1'b0;
   endtask

   task automatic clear_all();
      tmo_clr = 3'b111;
      step();
      tmo_clr = 3'b000;
   endtask

   task automatic pulse_start(int w);
      cyc_start[w] = 1'b1;
      step();
      cyc_start[w] = 1'b0;
   endtask

   task automatic run_timeout(int w, int s);
      int n = exp_lim(w, s);
      clear_all();
      check(tmo_flag == 3'b000, "R10 clear", int'(tmo_flag), 0);
      pulse_start(w);
      us_tick = 1'b1;
      for (int k = 1; k < n; k++) step();
      check(tmo_flag[w] == 1'b0, {sel_req(w), " R7 before limit"}, int'(tmo_flag[w]), 0);
      step();
      us_tick = 1'b0;
      check(tmo_flag[w] == 1'b1, {sel_req(w), " R7 at limit"}, int'(tmo_flag[w]), 1);
      check(bus_err == 1'b1, "R11 pulse", int'(bus_err), 1);
      step();
      check(bus_err == 1'b0, "R11 one clock", int'(bus_err), 0);
      check(tmo_flag[w] == 1'b1, "R10 sticky", int'(tmo_flag[w]), 1);
   endtask

   task automatic run_done(int w, int s);
      int n = exp_lim(w, s);
      clear_all();
      pulse_start(w);
      us_tick = 1'b1;
      for (int k = 1; k < n; k++) step();
      cyc_done[w] = 1'b1;
      step();
      cyc_done[w] = 1'b0;
      check(tmo_flag[w] == 1'b0 && bus_err == 1'b0, "R7 done on limit edge",
            int'(tmo_flag[w]), 0);
      for (int k = 0; k < 5; k++) step();
      us_tick = 1'b0;
      check(tmo_flag[w] == 1'b0, "R7 idle after done", int'(tmo_flag[w]), 0);
   endtask

   task automatic run_off(int w);
      int seen = 0;
      clear_all();
      wr_cfg(9, 3 << (2 * w));
      pulse_start(w);
      us_tick = 1'b1;
      for (int k = 0; k < 2000; k++) begin
         step();
         if (bus_err || tmo_flag[w]) seen++;
      end
      us_tick = 1'b0;
      check(seen == 0, "R8 disabled watcher", seen, 0);
      cyc_done[w] = 1'b1;
      step();
      cyc_done[w] = 1'b0;
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      errs++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin
      #1;
      for (int k = 0; k < 5; k++) step();
      check(tmo_flag == 3'b000, "R1 flags", int'(tmo_flag), 0);
      check(bus_err == 1'b0, "R1 bus_err", int'(bus_err), 0);
      check(arb_tmr_en == 1'b0, "R1 arb", int'(arb_tmr_en), 0);
      rst_n = 1'b1;
      step();

      // R1: reset selectors are 00, so watcher 2 times out at 102 with no write
      run_timeout(2, 0);

      // R3 R4 R5: sweep every limit of every watcher
      for (int w = 0; w < 3; w++) begin
         for (int s = 0; s < 3; s++) begin
            wr_cfg(9, s << (2 * w));
            run_timeout(w, s);
            if (exp_lim(w, s) <= 2000) run_done(w, s);
         end
      end

      // R8
      for (int w = 0; w < 3; w++) run_off(w);

      // R6
      wr_cfg(9, 8'h40);
      check(arb_tmr_en == 1'b1, "R6 set", int'(arb_tmr_en), 1);
      wr_cfg(9, 8'h00);
      check(arb_tmr_en == 1'b0, "R6 clear", int'(arb_tmr_en), 0);

      // R2: a write elsewhere changes nothing
      wr_cfg(11, 8'hFF);
      check(arb_tmr_en == 1'b0, "R2 arb untouched", int'(arb_tmr_en), 0);
      run_timeout(0, 0);

      // R9: limit latched at start survives a rewrite
      wr_cfg(9, 8'h00);
      clear_all();
      pulse_start(0);
      us_tick = 1'b1;
      for (int k = 0; k < 50; k++) step();
      us_tick = 1'b0;
      wr_cfg(9, 8'h02);
      us_tick = 1'b1;
      for (int k = 0; k < 51; k++) step();
      check(tmo_flag[0] == 1'b0, "R9 before old limit", int'(tmo_flag[0]), 0);
      step();
      us_tick = 1'b0;
      check(tmo_flag[0] == 1'b1, "R9 old limit kept", int'(tmo_flag[0]), 1);

      // R10: other clear bits leave the flag, its own bit clears it
      tmo_clr = 3'b110;
      step();
      tmo_clr = 3'b000;
      check(tmo_flag[0] == 1'b1, "R10 other clear", int'(tmo_flag[0]), 1);
      tmo_clr = 3'b001;
      step();
      tmo_clr = 3'b000;
      check(tmo_flag[0] == 1'b0, "R10 own clear", int'(tmo_flag[0]), 0);

      // R9: the next cycle picks up the new 410 limit
      run_timeout(0, 2);

      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end
endmodule